// File: doc/BRIEF.md
# Receive Status and Interrupt Register

This block holds eight sticky status flags for a network receive path. Internal logic sets each flag with a one-cycle event pulse. The flag then stays set until software clears it. Each flag can raise a shared interrupt line through a matching bit of an enable mask that comes in as an 8-bit input.

The host reads all eight flags at once through a byte-wide register port. Writing a one to a flag clears it, with one exception: the DMA-completion flag. The host cannot write that flag through this register. It clears only when a zero byte is written to a separate DMA control register. While it is set, the block blocks the DMA request line that passes through it.

A bus-read watchdog is built in. It starts counting at each rising edge of the bus read strobe. If no ready response arrives within a fixed time (2.4 µs by default), it raises the read-error flag. A parameter gives the clock frequency, and the block derives the limit in cycles from it.

Top module: `rxs_irq_status`

## Requirements
- R1: After reset, all flags read 0 and the interrupt output is low.
- R2: Each flag sets one cycle after its event input is high at a clock edge and then holds. The bit positions are: 7 packet stored, 6 bus read error, 5 DMA end of process, 4 remote-control packet, 3 short packet, 2 alignment error, 1 CRC error, 0 buffer overflow.
- R3: A host write clears every flag except bit 5 whose written data bit is 1. Written 0 bits leave their flag unchanged.
- R4: A host write does not change bit 5. Bit 5 clears only on a DMA control write whose data is 00h. A DMA control write with non-zero data has no effect on it.
- R5: The DMA request output equals the DMA request input while bit 5 is clear, and is held low while bit 5 is set.
- R6: With no ready response, bit 6 sets at the clock edge that comes TMO_CYC edges after the edge that first samples the read strobe high. TMO_CYC is 120 at the default 50 MHz.
- R7: A ready response before the limit cancels the count. A read strobe that stays high afterwards does not restart the count; only a new rising edge does.
- R8: The interrupt output is high in the same cycle as any flag whose enable bit is 1, and low when no enabled flag is set.
- R9: If an event and a clearing write for the same flag happen in the same cycle, the flag ends set.
- R10: Writing back a value read earlier clears exactly the flags in that value, and keeps flags that were set after the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe for the status register |
| host_wdata | input | 8 | Host write data (1 = clear that flag) |
| host_rdata | output | 8 | Current status flags |
| ev_pkt | input | 1 | Packet stored event |
| ev_remote | input | 1 | Remote-control packet event |
| ev_short | input | 1 | Short packet event |
| ev_align | input | 1 | Alignment error event |
| ev_crc | input | 1 | CRC error event |
| ev_ovf | input | 1 | Buffer overflow event |
| dma_eop | input | 1 | DMA end-of-process event |
| dma_ctl_wr | input | 1 | Write strobe of the DMA control register |
| dma_ctl_wdata | input | 8 | Data of the DMA control write |
| dma_req_in | input | 1 | DMA request from the receive logic |
| dma_req_out | output | 1 | Gated DMA request to the host |
| bus_rd | input | 1 | Bus read strobe |
| bus_rdy | input | 1 | Ready response to the bus read |
| irq_en | input | 8 | Interrupt enable mask |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the edges of the clearing rules.

- Write-back with a newer event: it writes back an old read value after a newer event has arrived. A design that clears all bits would lose the new flag.
- Set against clear: it clears a flag in the same cycle its event fires. A design that lets the clear win would drop the event.
- DMA-completion flag: it attacks the flag with host writes and with non-zero DMA control writes. A design that treats it as write-one-to-clear would release the gated DMA request too early.
- Watchdog boundary: it checks the cycle just before and the cycle of the read-timeout limit. It also checks that a ready response or a strobe held high never produces a late error. An off-by-one counter, or one that rearms on a level instead of an edge, would fail these checks.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int FLAG_W   = 8;
    localparam int B_PKT    = 7;
    localparam int B_RDERR  = 6;
    localparam int B_EOP    = 5;
    localparam int B_REMOTE = 4;
    localparam int B_SHORT  = 3;
    localparam int B_ALIGN  = 2;
    localparam int B_CRC    = 1;
    localparam int B_OVF    = 0;

    typedef logic [FLAG_W-1:0] flags_t;

    // host-writable (write-one-to-clear) mask: every flag except end-of-process
    localparam flags_t W1C_MASK = ~(flags_t'(1) << B_EOP);
endpackage

// File: rtl/rxs_rd_timeout.sv
module rxs_rd_timeout #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int TIMEOUT_NS = 2400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_strobe,
    input  logic rdy,
    output logic expired
);
    localparam longint RAW_CYC = (longint'(CLK_HZ) * TIMEOUT_NS) / 64'd1_000_000_000;
    localparam int TMO_CYC = (RAW_CYC < 1) ? 1 : int'(RAW_CYC);
    localparam int CNT_W   = $clog2(TMO_CYC + 1);

    typedef struct packed {
        logic             prev;
        logic             active;
        logic [CNT_W-1:0] cnt;
    } tmo_t;

    tmo_t st_d, st_q;
    logic hit;

    assign hit     = st_q.active && !rdy && (st_q.cnt == CNT_W'(TMO_CYC - 1));
    assign expired = hit;

    always_comb begin
        st_d      = st_q;
        st_d.prev = rd_strobe;
        if (rd_strobe && !st_q.prev) begin
            st_d.active = 1'b1;
            st_d.cnt    = '0;
        end else if (st_q.active) begin
            if (rdy || hit) begin
                st_d.active = 1'b0;
                st_d.cnt    = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rxs_flag_bank.sv
module rxs_flag_bank
    import rxs_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  flags_t set_vec,
    input  logic   host_wr,
    input  flags_t host_wdata,
    input  logic   eop_clr,
    output flags_t flags
);
    typedef struct packed {
        flags_t flags;
    } bank_t;

    bank_t st_d, st_q;
    flags_t clr_vec;

    always_comb begin
        clr_vec = host_wr ? (host_wdata & W1C_MASK) : '0;
        if (eop_clr) clr_vec[B_EOP] = 1'b1;
        st_d       = st_q;
        // set wins over clear in the same cycle
        st_d.flags = (st_q.flags & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flags = st_q.flags;
endmodule

// File: rtl/rxs_irq_status.sv
module rxs_irq_status
    import rxs_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int TIMEOUT_NS = 2400
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_wr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       ev_pkt,
    input  logic       ev_remote,
    input  logic       ev_short,
    input  logic       ev_align,
    input  logic       ev_crc,
    input  logic       ev_ovf,
    input  logic       dma_eop,
    input  logic       dma_ctl_wr,
    input  logic [7:0] dma_ctl_wdata,
    input  logic       dma_req_in,
    output logic       dma_req_out,
    input  logic       bus_rd,
    input  logic       bus_rdy,
    input  logic [7:0] irq_en,
    output logic       irq
);
    flags_t set_vec, flags;
    logic   rd_expired, eop_clr;

    rxs_rd_timeout #(.CLK_HZ(CLK_HZ), .TIMEOUT_NS(TIMEOUT_NS)) i_tmo (
        .clk(clk), .rst_n(rst_n), .rd_strobe(bus_rd), .rdy(bus_rdy), .expired(rd_expired)
    );

    always_comb begin
        set_vec           = '0;
        set_vec[B_PKT]    = ev_pkt;
        set_vec[B_RDERR]  = rd_expired;
        set_vec[B_EOP]    = dma_eop;
        set_vec[B_REMOTE] = ev_remote;
        set_vec[B_SHORT]  = ev_short;
        set_vec[B_ALIGN]  = ev_align;
        set_vec[B_CRC]    = ev_crc;
        set_vec[B_OVF]    = ev_ovf;
    end

    assign eop_clr = dma_ctl_wr && (dma_ctl_wdata == 8'h00);

    rxs_flag_bank i_bank (
        .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .host_wr(host_wr),
        .host_wdata(host_wdata), .eop_clr(eop_clr), .flags(flags)
    );

    assign host_rdata  = flags;
    assign dma_req_out = dma_req_in && !flags[B_EOP];
    assign irq         = |(flags & irq_en);
endmodule

// File: rtl/rxs_irq_status_chk.sv
module rxs_irq_status_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       host_wr,
    input logic [7:0] host_wdata,
    input logic [7:0] host_rdata,
    input logic       ev_crc,
    input logic       ev_ovf,
    input logic       ev_pkt,
    input logic       dma_ctl_wr,
    input logic [7:0] dma_ctl_wdata,
    input logic       dma_req_out,
    input logic [7:0] irq_en,
    input logic       irq
);
    // R2
    set_chk: assert property (@(posedge clk) disable iff (!rst_n) ev_crc |=> host_rdata[1]);
    // R9
    setwins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ovf && host_wr && host_wdata[0]) |=> host_rdata[0]);
    // R3
    w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_wdata[7] && !ev_pkt) |=> !host_rdata[7]);
    // R4
    eop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rdata[5] && !(dma_ctl_wr && dma_ctl_wdata == 8'h00)) |=> host_rdata[5]);
    // R5
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_rdata[5] |-> !dma_req_out);
    // R8
    irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(host_rdata & irq_en) == 0) |-> !irq);
endmodule

bind rxs_irq_status rxs_irq_status_chk i_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .ev_crc(ev_crc), .ev_ovf(ev_ovf), .ev_pkt(ev_pkt),
    .dma_ctl_wr(dma_ctl_wr), .dma_ctl_wdata(dma_ctl_wdata),
    .dma_req_out(dma_req_out), .irq_en(irq_en), .irq(irq)
);

// File: tb/test_rxs_irq_status.sv
module test_rxs_irq_status;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       ev_pkt = 0, ev_remote = 0, ev_short = 0, ev_align = 0, ev_crc = 0, ev_ovf = 0;
    logic       dma_eop = 0, dma_ctl_wr = 0;
    logic [7:0] dma_ctl_wdata = '0;
    logic       dma_req_in = 0, dma_req_out;
    logic       bus_rd = 0, bus_rdy = 0;
    logic [7:0] irq_en = '0;
    logic       irq;

    int n_run = 0, n_fail = 0;
    localparam int TMO = 120;

    always #10 clk = ~clk;

    rxs_irq_status i_rxs_irq_status (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .ev_pkt(ev_pkt), .ev_remote(ev_remote),
        .ev_short(ev_short), .ev_align(ev_align), .ev_crc(ev_crc), .ev_ovf(ev_ovf),
        .dma_eop(dma_eop), .dma_ctl_wr(dma_ctl_wr), .dma_ctl_wdata(dma_ctl_wdata),
        .dma_req_in(dma_req_in), .dma_req_out(dma_req_out), .bus_rd(bus_rd),
        .bus_rdy(bus_rdy), .irq_en(irq_en), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse_event(input int b);
        case (b)
            7: ev_pkt = 1;  4: ev_remote = 1; 3: ev_short = 1;
            2: ev_align = 1; 1: ev_crc = 1;   0: ev_ovf = 1;
            5: dma_eop = 1;
            default: ;
        endcase
        tick();
        {ev_pkt, ev_remote, ev_short, ev_align, ev_crc, ev_ovf, dma_eop} = '0;
    endtask

    task automatic host_write(input logic [7:0] v);
        host_wr = 1; host_wdata = v; tick(); host_wr = 0; host_wdata = '0;
    endtask

    task automatic dma_write(input logic [7:0] v);
        dma_ctl_wr = 1; dma_ctl_wdata = v; tick(); dma_ctl_wr = 0; dma_ctl_wdata = '0;
    endtask

    task automatic do_reset();
        rst_n = 0; tick(); tick(); rst_n = 1;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 flags", host_rdata, 8'h00);
        irq_en = 8'hFF;
        check("R1 irq", {7'b0, irq}, 8'h00);
        irq_en = 8'h00;
    endtask

    task automatic t_set_each();
        logic [7:0] exp = '0;
        foreach (exp[i]) begin
            if (i == 6) continue;
            pulse_event(i);
            exp[i] = 1'b1;
            check("R2 set", host_rdata, exp);
        end
        tick(); tick();
        check("R2 hold", host_rdata, exp);
    endtask

    task automatic t_w1c();
        // flags now 0xBF (all but bit 6)
        host_write(8'h00);
        check("R3 zero write", host_rdata, 8'hBF);
        host_write(8'h0A);
        check("R3 partial clear", host_rdata, 8'hB5);
        host_write(8'hFF);
        check("R4 host write keeps bit5", host_rdata, 8'h20);
    endtask

    task automatic t_eop();
        dma_req_in = 1;
        #1 check("R5 gated", {7'b0, dma_req_out}, 8'h00);
        dma_write(8'h01);
        check("R4 nonzero dma write", host_rdata, 8'h20);
        dma_write(8'h00);
        check("R4 zero dma write", host_rdata, 8'h00);
        check("R5 released", {7'b0, dma_req_out}, 8'h01);
        dma_req_in = 0;
        #1 check("R5 follows input", {7'b0, dma_req_out}, 8'h00);
    endtask

    task automatic t_irq();
        pulse_event(1);
        irq_en = 8'h80;
        #1 check("R8 masked", {7'b0, irq}, 8'h00);
        irq_en = 8'h02;
        #1 check("R8 enabled", {7'b0, irq}, 8'h01);
        host_write(8'h02);
        check("R8 cleared", {7'b0, irq}, 8'h00);
        irq_en = 8'h00;
    endtask

    task automatic t_set_wins();
        pulse_event(0);
        ev_ovf = 1; host_wr = 1; host_wdata = 8'h01;
        tick();
        ev_ovf = 0; host_wr = 0; host_wdata = '0;
        check("R9 set beats clear", host_rdata, 8'h01);
        host_write(8'h01);
    endtask

    task automatic t_writeback();
        logic [7:0] snap;
        pulse_event(3);
        pulse_event(2);
        snap = host_rdata;
        pulse_event(7);
        host_write(snap);
        check("R10 writeback", host_rdata, 8'h80);
        host_write(8'h80);
    endtask

    task automatic t_timeout();
        bus_rd = 1;
        repeat (TMO) tick();
        check("R6 before limit", host_rdata, 8'h00);
        tick();
        check("R6 at limit", host_rdata, 8'h40);
        bus_rd = 0;
        host_write(8'h40);
        check("R3 clear rd err", host_rdata, 8'h00);
    endtask

    task automatic t_ready();
        bus_rd = 1;
        repeat (50) tick();
        bus_rdy = 1; tick(); bus_rdy = 0;
        repeat (2 * TMO) tick();
        check("R7 ready cancels", host_rdata, 8'h00);
        bus_rd = 0; tick();
        bus_rd = 1;
        repeat (TMO + 1) tick();
        check("R7 new edge rearms", host_rdata, 8'h40);
        bus_rd = 0;
        host_write(8'h40);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_set_each();
        t_w1c();
        t_eop();
        t_irq();
        t_set_wins();
        t_writeback();
        t_timeout();
        t_ready();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule